// File: doc/BRIEF.md
# Stored-Pattern Serial Waveform Player

This block turns a run of 32-bit words, held in a small internal RAM, into a serial waveform on one output pin. Every bit of a word drives the pin to its own value: a one holds the pin high for a programmable number of clocks, and a zero holds it low for a separately programmed number of clocks. Within each word the bits leave least-significant first and stop at a programmable bit position. The words are read from a programmable start address for a programmed number of words. The address wraps around the end of the RAM.

Software fills the RAM through a plain write port. It then sets the start address, the word count, the two bit hold times, the last-bit position, a pass count, the guard level and guard length, and the idle level, and pulses `start`. The block samples the whole configuration on that pulse. It plays the buffer once per pass and drives the guard level for the guard length between passes. When the final bit has run out it pulses `done` for one cycle and returns the pin to the idle level. A `halt` input drops the pin to the idle level at once and abandons the playback.

Top module: `pwm_word_player`

## Requirements
- R1: Within each word the bits go out from bit 0 upward, ending at bit `stopBit` inclusive (31 sends the whole word). Words are taken from RAM addresses `baseAddr`, `baseAddr+1`, … for `lenWords` words, and the address wraps modulo the RAM depth.
- R2: A bit of value 1 drives `pinOut` high for `hiDur`+1 clocks. A bit of value 0 drives it low for `loDur`+1 clocks.
- R3: A `start` pulse seen at a clock edge while idle, with `halt` low and `lenWords` non-zero, makes `busy` high and puts bit 0 of the first word on `pinOut` in the cycle after that edge. The configuration is captured at that edge, so later changes on the configuration ports do not alter the waveform.
- R4: `repeatCnt` = N plays the whole buffer N times. A value of 0 or 1 plays it exactly once.
- R5: Between two passes the pin is held at `guardLvl` for `guardDur` clocks. With `guardDur` = 0 the next pass follows with no gap.
- R6: `done` is high for exactly one cycle: the cycle right after the last clock of the final bit. In that same cycle `busy` is low.
- R7: Whenever no playback is running, `pinOut` equals the live value of `idleLvl`.
- R8: A `start` pulse while `busy` is high is ignored, and the running waveform continues unchanged.
- R9: While `halt` is high, `pinOut` equals `idleLvl` in the same cycle. The playback ends without a `done` pulse, and `start` is ignored.
- R10: A `start` with `lenWords` = 0 is ignored, and `busy` stays low.
- R11: After reset `busy`, `done` and `pinOut` (with `idleLvl` low) are low. A word written through `wrEn`/`wrAddr`/`wrData` is the one played by the next run that reads that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | RAM write strobe |
| wrAddr | input | AW | RAM write address |
| wrData | input | 32 | RAM write word |
| baseAddr | input | AW | First word address of the run |
| lenWords | input | AW+1 | Number of words to play |
| hiDur | input | DUR_W | Hold time minus one for a 1 bit |
| loDur | input | DUR_W | Hold time minus one for a 0 bit |
| stopBit | input | 5 | Last bit index sent from each word |
| idleLvl | input | 1 | Pin level when not playing |
| guardLvl | input | 1 | Pin level between passes |
| guardDur | input | DUR_W | Clocks of guard level between passes |
| repeatCnt | input | REP_W | Number of passes (0 counts as 1) |
| start | input | 1 | Start pulse |
| halt | input | 1 | Immediate stop, forces idle level |
| pinOut | output | 1 | Serial waveform output |
| busy | output | 1 | Playback in progress |
| done | output | 1 | One-cycle end-of-playback pulse |

## Verification
A wrong bit or word index appears on `pinOut` in the first hold period that uses it. Because the bench compares the pin against its own model on every cycle, such a fault is caught within one bit time. A hold counter that is off by one moves every later edge by one clock and is reported at the first bit boundary. A faulty pass count or guard sequencer shows up at the end of the first pass, either as a missing or extra gap or as `done` arriving a pass early or late. Faults in the end-of-run and halt logic show up within one cycle, as a `done` that is missing, lasts two cycles or comes after a halt, or as a pin that does not follow `idleLvl`.

// File: rtl/pwm_ser_pkg.sv
package pwm_ser_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PLAY  = 2'd1,
    ST_GUARD = 2'd2
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic cfgLoad;    // capture configuration ports
    logic bitLoad;    // fetch the bit at rdWord/rdBit and load its hold time
    logic guardLoad;  // load the guard hold time
  } seqStrb_t;

endpackage

// File: rtl/pwm_ser_path.sv
module pwm_ser_path
  import pwm_ser_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DUR_W = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [31:0]      wrData,
  input  logic [AW-1:0]    baseIn,
  input  logic [DUR_W-1:0] hiIn,
  input  logic [DUR_W-1:0] loIn,
  input  logic             guardLvlIn,
  input  logic [DUR_W-1:0] guardDurIn,
  input  seqStrb_t         strb,
  input  logic [AW-1:0]    rdWord,
  input  logic [4:0]       rdBit,
  output logic             curBit,
  output logic             guardLvl,
  output logic             holdZero
);

  logic [31:0]      wordMem [DEPTH];
  logic [AW-1:0]    baseR;
  logic [DUR_W-1:0] hiR, loR, guardDurR, holdCnt;
  logic             guardLvlR, curBitR;

  logic [AW-1:0]    rdAddr;
  logic             bitVal;
  logic [DUR_W-1:0] hiSel, loSel;

  always_ff @(posedge clk) begin
    if (wrEn) wordMem[wrAddr] <= wrData;
  end

  // on the start edge the registers are not yet loaded: use the ports
  always_comb begin
    rdAddr = (strb.cfgLoad ? baseIn : baseR) + rdWord;
    bitVal = wordMem[rdAddr][rdBit];
    hiSel  = strb.cfgLoad ? hiIn : hiR;
    loSel  = strb.cfgLoad ? loIn : loR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseR     <= '0;
      hiR       <= '0;
      loR       <= '0;
      guardDurR <= '0;
      guardLvlR <= 1'b0;
    end else if (strb.cfgLoad) begin
      baseR     <= baseIn;
      hiR       <= hiIn;
      loR       <= loIn;
      guardDurR <= guardDurIn;
      guardLvlR <= guardLvlIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
      curBitR <= 1'b0;
    end else if (strb.guardLoad) begin
      holdCnt <= guardDurR - 1'b1;
    end else if (strb.bitLoad) begin
      curBitR <= bitVal;
      holdCnt <= bitVal ? hiSel : loSel;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  assign curBit   = curBitR;
  assign guardLvl = guardLvlR;
  assign holdZero = (holdCnt == '0);

endmodule

// File: rtl/pwm_ser_ctrl.sv
module pwm_ser_ctrl
  import pwm_ser_pkg::*;
#(
  parameter int AW    = 4,
  parameter int REP_W = 8,
  parameter int LEN_W = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             halt,
  input  logic [LEN_W-1:0] lenIn,
  input  logic [REP_W-1:0] repIn,
  input  logic [4:0]       stopIn,
  input  logic             guardOnIn,
  input  logic             holdZero,
  output seqStrb_t         strb,
  output logic [AW-1:0]    rdWord,
  output logic [4:0]       rdBit,
  output logic             inPlay,
  output logic             inGuard,
  output logic             busy,
  output logic             done
);

  localparam int PW = REP_W + 1;

  seqState_t        state, stateNxt;
  logic [AW-1:0]    wordIdx, wordNxt;
  logic [4:0]       bitIdx, bitNxt;
  logic [REP_W-1:0] passCnt, passNxt;
  logic [LEN_W-1:0] lenR;
  logic [REP_W-1:0] repR, repEff;
  logic [4:0]       stopR;
  logic             guardOnR, doneR, doneNxt;
  logic             lastBit, lastWord, lastPass;

  always_comb begin
    repEff   = (repR == '0) ? REP_W'(1) : repR;
    lastBit  = (bitIdx == stopR);
    lastWord = (LEN_W'(wordIdx) + LEN_W'(1)) >= lenR;
    lastPass = (PW'(passCnt) + PW'(1)) >= PW'(repEff);
  end

  always_comb begin
    stateNxt = state;
    wordNxt  = wordIdx;
    bitNxt   = bitIdx;
    passNxt  = passCnt;
    doneNxt  = 1'b0;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (start && lenIn != '0) begin
          strb.cfgLoad = 1'b1;
          strb.bitLoad = 1'b1;
          wordNxt      = '0;
          bitNxt       = '0;
          passNxt      = '0;
          stateNxt     = ST_PLAY;
        end
      end
      ST_PLAY: begin
        if (holdZero) begin
          if (!lastBit) begin
            bitNxt       = bitIdx + 5'd1;
            strb.bitLoad = 1'b1;
          end else if (!lastWord) begin
            wordNxt      = wordIdx + 1'b1;
            bitNxt       = '0;
            strb.bitLoad = 1'b1;
          end else if (!lastPass) begin
            passNxt = passCnt + 1'b1;
            wordNxt = '0;
            bitNxt  = '0;
            if (guardOnR) begin
              strb.guardLoad = 1'b1;
              stateNxt       = ST_GUARD;
            end else begin
              strb.bitLoad = 1'b1;
            end
          end else begin
            stateNxt = ST_IDLE;
            doneNxt  = 1'b1;
          end
        end
      end
      ST_GUARD: begin
        if (holdZero) begin
          strb.bitLoad = 1'b1;
          stateNxt     = ST_PLAY;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
    if (halt) begin
      stateNxt = ST_IDLE;
      doneNxt  = 1'b0;
      strb     = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
      bitIdx  <= '0;
      passCnt <= '0;
      doneR   <= 1'b0;
    end else begin
      state   <= stateNxt;
      wordIdx <= wordNxt;
      bitIdx  <= bitNxt;
      passCnt <= passNxt;
      doneR   <= doneNxt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenR     <= '0;
      repR     <= '0;
      stopR    <= '0;
      guardOnR <= 1'b0;
    end else if (strb.cfgLoad) begin
      lenR     <= lenIn;
      repR     <= repIn;
      stopR    <= stopIn;
      guardOnR <= guardOnIn;
    end
  end

  assign rdWord  = wordNxt;
  assign rdBit   = bitNxt;
  assign inPlay  = (state == ST_PLAY);
  assign inGuard = (state == ST_GUARD);
  assign busy    = (state != ST_IDLE);
  assign done    = doneR;

endmodule

// File: rtl/pwm_word_player.sv
module pwm_word_player
  import pwm_ser_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DUR_W = 16,
  parameter int REP_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [31:0]      wrData,
  input  logic [AW-1:0]    baseAddr,
  input  logic [LEN_W-1:0] lenWords,
  input  logic [DUR_W-1:0] hiDur,
  input  logic [DUR_W-1:0] loDur,
  input  logic [4:0]       stopBit,
  input  logic             idleLvl,
  input  logic             guardLvl,
  input  logic [DUR_W-1:0] guardDur,
  input  logic [REP_W-1:0] repeatCnt,
  input  logic             start,
  input  logic             halt,
  output logic             pinOut,
  output logic             busy,
  output logic             done
);

  seqStrb_t      strb;
  logic [AW-1:0] rdWord;
  logic [4:0]    rdBit;
  logic          curBit, guardLvlR, holdZero, inPlay, inGuard;

  pwm_ser_ctrl #(.AW(AW), .REP_W(REP_W), .LEN_W(LEN_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .halt     (halt),
    .lenIn    (lenWords),
    .repIn    (repeatCnt),
    .stopIn   (stopBit),
    .guardOnIn(guardDur != '0),
    .holdZero (holdZero),
    .strb     (strb),
    .rdWord   (rdWord),
    .rdBit    (rdBit),
    .inPlay   (inPlay),
    .inGuard  (inGuard),
    .busy     (busy),
    .done     (done)
  );

  pwm_ser_path #(.DEPTH(DEPTH), .DUR_W(DUR_W), .AW(AW)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .baseIn    (baseAddr),
    .hiIn      (hiDur),
    .loIn      (loDur),
    .guardLvlIn(guardLvl),
    .guardDurIn(guardDur),
    .strb      (strb),
    .rdWord    (rdWord),
    .rdBit     (rdBit),
    .curBit    (curBit),
    .guardLvl  (guardLvlR),
    .holdZero  (holdZero)
  );

  always_comb begin
    if (halt)         pinOut = idleLvl;
    else if (inPlay)  pinOut = curBit;
    else if (inGuard) pinOut = guardLvlR;
    else              pinOut = idleLvl;
  end

endmodule

// File: rtl/pwm_word_player_chk.sv
module pwm_word_player_chk #(
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             halt,
  input logic [LEN_W-1:0] lenWords,
  input logic             idleLvl,
  input logic             pinOut,
  input logic             busy,
  input logic             done
);

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !halt && lenWords != '0) |=> busy); // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))); // R6

  AST_IDLE_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !halt) |-> (pinOut == idleLvl)); // R7

  AST_HALT_PIN: assert property (@(posedge clk) disable iff (!rstN)
    halt |-> (pinOut == idleLvl)); // R9

  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    halt |=> (!busy && !done)); // R9

  AST_LEN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && lenWords == '0) |=> !busy); // R10

endmodule

bind pwm_word_player pwm_word_player_chk #(.LEN_W(LEN_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .halt    (halt),
  .lenWords(lenWords),
  .idleLvl (idleLvl),
  .pinOut  (pinOut),
  .busy    (busy),
  .done    (done)
);

// File: tb/tb_pwm_word_player.sv
module tb_pwm_word_player;

  localparam int DEPTH = 16;
  localparam int DUR_W = 16;
  localparam int REP_W = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int LEN_W = AW + 1;

  typedef struct packed {
    logic [3:0] base;
    logic [4:0] len;
    logic [7:0] hi;
    logic [7:0] lo;
    logic [4:0] stop;
    logic       gLvl;
    logic [7:0] gDur;
    logic [7:0] rep;
    logic       idle;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{4'd0,  5'd1, 8'd0, 8'd0, 5'd31, 1'b0, 8'd0, 8'd1, 1'b0},
    '{4'd3,  5'd2, 8'd2, 8'd1, 5'd7,  1'b0, 8'd0, 8'd1, 1'b0},
    '{4'd14, 5'd3, 8'd1, 8'd0, 5'd3,  1'b0, 8'd0, 8'd1, 1'b0},
    '{4'd5,  5'd1, 8'd0, 8'd1, 5'd4,  1'b1, 8'd3, 8'd3, 1'b0},
    '{4'd2,  5'd2, 8'd1, 8'd1, 5'd2,  1'b1, 8'd0, 8'd2, 1'b0},
    '{4'd7,  5'd1, 8'd0, 8'd0, 5'd5,  1'b0, 8'd0, 8'd0, 1'b1}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [AW-1:0]    wrAddr = '0;
  logic [31:0]      wrData = '0;
  logic [AW-1:0]    baseAddr = '0;
  logic [LEN_W-1:0] lenWords = '0;
  logic [DUR_W-1:0] hiDur = '0, loDur = '0, guardDur = '0;
  logic [4:0]       stopBit = '0;
  logic             idleLvl = 1'b0, guardLvl = 1'b0;
  logic [REP_W-1:0] repeatCnt = '0;
  logic             start = 1'b0, halt = 1'b0;
  logic             pinOut, busy, done;

  logic [31:0] wordsM [DEPTH];
  int checkCnt = 0;
  int failCnt  = 0;
  int cycIdx, pokeAt, mism;
  logic firstAct, firstExp;
  int firstCyc;
  logic [AW-1:0]    pokeBase;
  logic [DUR_W-1:0] pokeHi;

  always #5 clk = ~clk;

  pwm_word_player #(.DEPTH(DEPTH), .DUR_W(DUR_W), .REP_W(REP_W)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .baseAddr(baseAddr), .lenWords(lenWords), .hiDur(hiDur), .loDur(loDur),
    .stopBit(stopBit), .idleLvl(idleLvl), .guardLvl(guardLvl),
    .guardDur(guardDur), .repeatCnt(repeatCnt), .start(start), .halt(halt),
    .pinOut(pinOut), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic writeWord(input int a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(a); wrData = d;
    wordsM[a] = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // one sampled cycle of the expected waveform
  task automatic stepCheck(input logic expLvl);
    @(negedge clk);
    if (cycIdx == 0) start = 1'b0;
    if (pokeAt >= 0 && cycIdx == pokeAt) begin
      start = 1'b1; baseAddr = pokeBase; hiDur = pokeHi;   // R8 stimulus
    end
    if (pokeAt >= 0 && cycIdx == pokeAt + 1) start = 1'b0;
    if ((pinOut !== expLvl || busy !== 1'b1) && mism == 0) begin
      firstAct = pinOut; firstExp = expLvl; firstCyc = cycIdx;
    end
    if (pinOut !== expLvl || busy !== 1'b1) mism++;
    cycIdx++;
  endtask

  task automatic doRun(input vec_t v, input int poke, input string req);
    int repEff;
    logic b;
    repEff = (v.rep == 0) ? 1 : int'(v.rep);
    @(negedge clk);
    baseAddr = v.base; lenWords = v.len; hiDur = DUR_W'(v.hi);
    loDur = DUR_W'(v.lo); stopBit = v.stop; guardLvl = v.gLvl;
    guardDur = DUR_W'(v.gDur); repeatCnt = v.rep; idleLvl = v.idle;
    start = 1'b1;
    cycIdx = 0; mism = 0; pokeAt = poke;
    pokeBase = AW'(v.base + 3); pokeHi = DUR_W'(v.hi + 2);
    for (int p = 0; p < repEff; p++) begin
      if (p > 0) for (int g = 0; g < int'(v.gDur); g++) stepCheck(v.gLvl);
      for (int w = 0; w < int'(v.len); w++)
        for (int k = 0; k <= int'(v.stop); k++) begin
          b = wordsM[(int'(v.base) + w) % DEPTH][k];
          for (int n = 0; n <= (b ? int'(v.hi) : int'(v.lo)); n++) stepCheck(b);
        end
    end
    chk(mism == 0, req, $sformatf("waveform mismatch at cycle %0d", firstCyc),
        32'(firstAct), 32'(firstExp));
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, "R6", "done/busy after last bit",
        {30'd0, done, busy}, 32'h2);
    chk(pinOut === v.idle, "R7", "idle level after run", 32'(pinOut), 32'(v.idle));
    @(negedge clk);
    chk(done === 1'b0, "R6", "done width", 32'(done), 32'h0);
  endtask

  function automatic string vecTag(input int i);
    case (i)
      0: return "R1";
      1: return "R2";
      2: return "R1 wrap";
      3: return "R4/R5 guard";
      4: return "R5 no-gap";
      default: return "R4 R11";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++; checkCnt++;
    $display("FAIL R6 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    vec_t vLong, vHalt;
    for (int i = 0; i < DEPTH; i++) wordsM[i] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy === 1'b0 && done === 1'b0 && pinOut === 1'b0, "R11", "reset outputs",
        {29'd0, busy, done, pinOut}, 32'h0);
    rstN = 1'b1;
    for (int i = 0; i < DEPTH; i++)
      writeWord(i, (32'h9E3779B9 * 32'(i + 1)) ^ 32'(i << 3));
    writeWord(7, 32'h0000_002D);   // R11 overwrite, played by entry 5

    for (int i = 0; i < NVEC; i++) doRun(VECS[i], -1, vecTag(i));

    // R8: start pulse during playback with other config
    doRun(VECS[1], 4, "R8");

    // R2 long hold using the default-style value 229
    writeWord(9, 32'h0000_0001);
    vLong = '{4'd9, 5'd1, 8'd229, 8'd5, 5'd1, 1'b0, 8'd0, 8'd1, 1'b0};
    doRun(vLong, -1, "R2 long");

    // R10: zero length start ignored
    @(negedge clk);
    lenWords = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b0, "R10", "busy after zero-length start", 32'(busy), 32'h0);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R10", "no run/done", {30'd0, busy, done}, 32'h0);

    // R9: halt mid-run
    vHalt = '{4'd0, 5'd2, 8'd3, 8'd3, 5'd31, 1'b0, 8'd0, 8'd1, 1'b0};
    @(negedge clk);
    baseAddr = vHalt.base; lenWords = vHalt.len; hiDur = 16'd3; loDur = 16'd3;
    stopBit = vHalt.stop; guardDur = '0; repeatCnt = 8'd1; idleLvl = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy === 1'b1, "R9", "busy before halt", 32'(busy), 32'h1);
    idleLvl = 1'b1; halt = 1'b1; start = 1'b1;
    #1;
    chk(pinOut === 1'b1, "R9", "pin forced idle same cycle", 32'(pinOut), 32'h1);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && pinOut === 1'b1, "R9", "stopped under halt",
        {29'd0, busy, done, pinOut}, 32'h1);
    halt = 1'b0; start = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R9", "no done after halt, start ignored",
        {30'd0, busy, done}, 32'h0);
    idleLvl = 1'b0;
    #1;
    chk(pinOut === 1'b0, "R7", "pin follows live idle level", 32'(pinOut), 32'h0);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule